// File: doc/BRIEF.md
# Windowed Sub-Sampling Readout Timer

This block sequences the readout of a raw Bayer pixel array on the pixel clock. A line begins with a programmable horizontal blanking stretch. A run of valid-pixel cycles follows, and during those cycles the block presents the array row and column to read. A frame is a programmable number of such lines. Lines past the window height become vertical blanking, although the horizontal timing keeps running through them.

The window can be placed anywhere in the array through a start column and a start row. Its width and height are programmed minus one. A digital skip factor of 1, 2 or 4 shrinks both axes. Decimation drops whole 2x2 Bayer cells, so consecutive output pixels come in adjacent pairs and the colour phase stays intact. The incoming 10-bit sample is passed through only on valid cycles.

All configuration inputs are sampled once per frame, at the frame boundary. A host can therefore rewrite them at any time without tearing the frame in progress.

Top module: `rdt_readout_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `hsync`, `vsync` and `pix_valid` are low and `row_addr`, `col_addr` and `pix_out` are zero. The first frame begins on the next cycle.
- R2: A line lasts `cfg_blank` + 1 + P cycles. The first `cfg_blank` + 1 of them have `hsync` low, and the remaining P have `hsync` high. `hsync` follows this pattern on every line of the frame.
- R3: P = (`cfg_hsize` + 1) >> S and the valid-line count L = (`cfg_vsize` + 1) >> S. S is derived from `cfg_skip`: code 0 gives S=0 (no skip), code 1 gives S=1 (divide by 2), and codes 2 and 3 give S=2 (divide by 4).
- R4: A frame has `cfg_lpf` lines, and the value 0 is treated as 1. `vsync` is high for every cycle of line 0 and low on all other lines.
- R5: `pix_valid` is high exactly on the `hsync`-high cycles of lines 0 to L-1. Lines from L onward carry `hsync` pulses with `pix_valid` low.
- R6: For output pixel k of a line (k = 0..P-1), `col_addr` = (`cfg_hstart` + (k/2)*2^(S+1) + (k mod 2)) mod 1024.
- R7: On output line n, `row_addr` = (`cfg_vstart` + (n/2)*2^(S+1) + (n mod 2)) mod 512.
- R8: `pix_out` equals `pix_in` while `pix_valid` is high. Otherwise `pix_out`, `row_addr` and `col_addr` are zero.
- R9: A change to any configuration input partway through a frame has no effect on that frame. The new values govern the following frame.
- R10: The first frame after reset uses the configuration present at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hstart | input | 10 | Window start column |
| cfg_vstart | input | 9 | Window start row |
| cfg_hsize | input | 10 | Window width minus one |
| cfg_vsize | input | 9 | Window height minus one |
| cfg_blank | input | 8 | Horizontal blanking length minus one |
| cfg_lpf | input | 14 | Lines per frame |
| cfg_skip | input | 2 | Skip code: 0 none, 1 divide by 2, 2 or 3 divide by 4 |
| pix_in | input | 10 | Pixel sample read at the presented address |
| hsync | output | 1 | High during the pixel part of each line |
| vsync | output | 1 | High throughout the first line of a frame |
| pix_valid | output | 1 | Pixel inside the window and on the skip grid |
| pix_out | output | 10 | Gated pixel sample |
| row_addr | output | 9 | Array row of the current valid pixel |
| col_addr | output | 10 | Array column of the current valid pixel |

## Verification
A corrupted column counter shows at the ports in the same cycle. The `hsync` edge moves, and `col_addr` breaks the pair-and-jump pattern within one or two pixels. A corrupted line counter shifts `vsync` and the valid-line boundary, and it shows by the next line start at the latest. A configuration captured at the wrong moment changes the pixel count or the addresses in the frame where a mid-frame rewrite is made. For that reason every frame of the sweep rewrites the configuration halfway through and then checks every cycle against the old values.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  typedef enum logic [1:0] {
    SKIP_NONE    = 2'd0,
    SKIP_HALF    = 2'd1,
    SKIP_QUARTER = 2'd2,
    SKIP_QUART_B = 2'd3
  } skip_e;

  function automatic logic [1:0] skip_shift(input logic [1:0] code);
    logic [1:0] s;
    case (skip_e'(code))
      SKIP_NONE:    s = 2'd0;
      SKIP_HALF:    s = 2'd1;
      default:      s = 2'd2;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rdt_shadow.sv
module rdt_shadow #(
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int BW = 8,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] in_hstart,
  input  logic [VW-1:0] in_vstart,
  input  logic [HW-1:0] in_hsize,
  input  logic [VW-1:0] in_vsize,
  input  logic [BW-1:0] in_blank,
  input  logic [LW-1:0] in_lpf,
  input  logic [1:0]    in_skip,
  output logic [HW-1:0] sh_hstart,
  output logic [VW-1:0] sh_vstart,
  output logic [HW-1:0] sh_hsize,
  output logic [VW-1:0] sh_vsize,
  output logic [BW-1:0] sh_blank,
  output logic [LW-1:0] sh_lpf,
  output logic [1:0]    sh_skip
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hstart <= '0;
      sh_vstart <= '0;
      sh_hsize  <= '0;
      sh_vsize  <= '0;
      sh_blank  <= '0;
      sh_lpf    <= '0;
      sh_skip   <= '0;
    end else if (load) begin
      sh_hstart <= in_hstart;
      sh_vstart <= in_vstart;
      sh_hsize  <= in_hsize;
      sh_vsize  <= in_vsize;
      sh_blank  <= in_blank;
      sh_lpf    <= in_lpf;
      sh_skip   <= in_skip;
    end
  end

endmodule

// File: rtl/rdt_counters.sv
module rdt_counters #(
  parameter int CW = 11,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] line_last,
  input  logic [LW-1:0] frame_last,
  output logic [CW-1:0] hcnt,
  output logic [LW-1:0] vcnt,
  output logic          eof
);

  logic          eol;
  logic [CW-1:0] hcnt_d;
  logic [LW-1:0] vcnt_d;

  always_comb begin
    eol    = hcnt >= line_last;
    eof    = eol && (vcnt >= frame_last);
    hcnt_d = hcnt;
    vcnt_d = vcnt;
    if (run) begin
      if (eol) begin
        hcnt_d = '0;
        vcnt_d = eof ? '0 : vcnt + 1'b1;
      end else begin
        hcnt_d = hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end

endmodule

// File: rtl/rdt_addr_map.sv
module rdt_addr_map #(
  parameter int IW = 11,
  parameter int OW = 10
) (
  input  logic [OW-1:0] base,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    shift,
  output logic [OW-1:0] addr
);

  localparam int SW = (IW > OW ? IW : OW) + 4;

  logic [SW-1:0] pair;
  logic [SW-1:0] offset;
  logic [SW-1:0] sum;

  always_comb begin
    pair   = SW'(idx >> 1);
    offset = (pair << ({1'b0, shift} + 3'd1)) | SW'(idx[0]);
    sum    = SW'(base) + offset;
    addr   = sum[OW-1:0];
  end

endmodule

// File: rtl/rdt_readout_timer.sv
module rdt_readout_timer #(
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int BW = 8,
  parameter int LW = 14,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_hstart,
  input  logic [VW-1:0] cfg_vstart,
  input  logic [HW-1:0] cfg_hsize,
  input  logic [VW-1:0] cfg_vsize,
  input  logic [BW-1:0] cfg_blank,
  input  logic [LW-1:0] cfg_lpf,
  input  logic [1:0]    cfg_skip,
  input  logic [DW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          pix_valid,
  output logic [DW-1:0] pix_out,
  output logic [VW-1:0] row_addr,
  output logic [HW-1:0] col_addr
);
  import rdt_pkg::*;

  localparam int NPW = HW + 1;
  localparam int NLW = VW + 1;
  localparam int CW  = (BW > NPW ? BW : NPW) + 1;
  localparam int RW  = (LW > NLW ? LW : NLW);

  logic          start_q;
  logic          eof;
  logic          load;
  logic [HW-1:0] sh_hstart, sh_hsize;
  logic [VW-1:0] sh_vstart, sh_vsize;
  logic [BW-1:0] sh_blank;
  logic [LW-1:0] sh_lpf;
  logic [1:0]    sh_skip;
  logic [1:0]    shift;
  logic [NPW-1:0] npix;
  logic [NLW-1:0] nlines;
  logic [CW-1:0] line_last;
  logic [LW-1:0] frame_last;
  logic [CW-1:0] hcnt;
  logic [LW-1:0] vcnt;
  logic [CW-1:0] kcol;
  logic          hs_i, line_ok, pv_i;
  logic [HW-1:0] col_map;
  logic [VW-1:0] row_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b1;
    else        start_q <= 1'b0;
  end

  assign load = start_q | eof;

  rdt_shadow #(.HW(HW), .VW(VW), .BW(BW), .LW(LW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_hstart(cfg_hstart), .in_vstart(cfg_vstart),
    .in_hsize(cfg_hsize), .in_vsize(cfg_vsize),
    .in_blank(cfg_blank), .in_lpf(cfg_lpf), .in_skip(cfg_skip),
    .sh_hstart(sh_hstart), .sh_vstart(sh_vstart),
    .sh_hsize(sh_hsize), .sh_vsize(sh_vsize),
    .sh_blank(sh_blank), .sh_lpf(sh_lpf), .sh_skip(sh_skip)
  );

  always_comb begin
    shift      = skip_shift(sh_skip);
    npix       = ({1'b0, sh_hsize} + 1'b1) >> shift;
    nlines     = ({1'b0, sh_vsize} + 1'b1) >> shift;
    line_last  = CW'(sh_blank) + CW'(npix);
    frame_last = (sh_lpf == '0) ? '0 : sh_lpf - 1'b1;
  end

  rdt_counters #(.CW(CW), .LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(!start_q),
    .line_last(line_last), .frame_last(frame_last),
    .hcnt(hcnt), .vcnt(vcnt), .eof(eof)
  );

  always_comb begin
    kcol    = hcnt - CW'(sh_blank) - 1'b1;
    hs_i    = !start_q && (hcnt > CW'(sh_blank));
    line_ok = RW'(vcnt) < RW'(nlines);
    pv_i    = hs_i && line_ok;
  end

  rdt_addr_map #(.IW(CW), .OW(HW)) u_col_map (
    .base(sh_hstart), .idx(kcol), .shift(shift), .addr(col_map)
  );

  rdt_addr_map #(.IW(LW), .OW(VW)) u_row_map (
    .base(sh_vstart), .idx(vcnt), .shift(shift), .addr(row_map)
  );

  always_comb begin
    hsync     = hs_i;
    vsync     = !start_q && (vcnt == '0);
    pix_valid = pv_i;
    pix_out   = pv_i ? pix_in  : '0;
    row_addr  = pv_i ? row_map : '0;
    col_addr  = pv_i ? col_map : '0;
  end

endmodule

// File: rtl/rdt_readout_timer_chk.sv
module rdt_readout_timer_chk #(
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int DW = 10,
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync,
  input logic          vsync,
  input logic          pix_valid,
  input logic [DW-1:0] pix_in,
  input logic [DW-1:0] pix_out,
  input logic [VW-1:0] row_addr,
  input logic [HW-1:0] col_addr,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] line_last
);

  a_r5_valid_inside_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> hsync);

  a_r8_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_out == '0 && row_addr == '0 && col_addr == '0));

  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_out == pix_in);

  a_r4_vsync_edge_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync) || $fell(vsync)) |-> !hsync);

  a_r7_row_const_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |-> row_addr == $past(row_addr));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= line_last);

endmodule

bind rdt_readout_timer rdt_readout_timer_chk #(
  .HW(HW), .VW(VW), .DW(DW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
  .pix_valid(pix_valid), .pix_in(pix_in), .pix_out(pix_out),
  .row_addr(row_addr), .col_addr(col_addr),
  .hcnt(hcnt), .line_last(line_last)
);

// File: tb/rdt_readout_timer_tb.sv
module rdt_readout_timer_tb;

  typedef struct {
    int hs; int vs; int hz; int vz; int bl; int lp; int sk;
  } cfg_t;

  localparam int NCFG = 13;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] cfg_hstart, cfg_hsize;
  logic [8:0] cfg_vstart, cfg_vsize;
  logic [7:0] cfg_blank;
  logic [13:0] cfg_lpf;
  logic [1:0] cfg_skip;
  logic [9:0] pix_in;
  logic       hsync, vsync, pix_valid;
  logic [9:0] pix_out;
  logic [8:0] row_addr;
  logic [9:0] col_addr;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  cfg_t list [NCFG];

  always #2 clk = ~clk;

  rdt_readout_timer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart),
    .cfg_hsize(cfg_hsize), .cfg_vsize(cfg_vsize),
    .cfg_blank(cfg_blank), .cfg_lpf(cfg_lpf), .cfg_skip(cfg_skip),
    .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .pix_valid(pix_valid),
    .pix_out(pix_out), .row_addr(row_addr), .col_addr(col_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (act != exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic apply(input cfg_t c);
    cfg_hstart = 10'(c.hs);
    cfg_vstart = 9'(c.vs);
    cfg_hsize  = 10'(c.hz);
    cfg_vsize  = 9'(c.vz);
    cfg_blank  = 8'(c.bl);
    cfg_lpf    = 14'(c.lp);
    cfg_skip   = 2'(c.sk);
  endtask

  task automatic check_idle(input string tag);
    check({tag, " hsync"}, int'(hsync), 0);
    check({tag, " vsync"}, int'(vsync), 0);
    check({tag, " pix_valid"}, int'(pix_valid), 0);
    check({tag, " pix_out"}, int'(pix_out), 0);
    check({tag, " row"}, int'(row_addr), 0);
    check({tag, " col"}, int'(col_addr), 0);
  endtask

  task automatic run_frame(input cfg_t c, input cfg_t nxt, input bit first);
    int sh, np, nl, lpe, len, k, ecol, erow, nvalid, nhs0;
    bit ehs, epv, changed;
    sh  = (c.sk >= 2) ? 2 : c.sk;
    np  = (c.hz + 1) >> sh;
    nl  = (c.vz + 1) >> sh;
    lpe = (c.lp == 0) ? 1 : c.lp;
    len = c.bl + 1 + np;
    nvalid = 0;
    nhs0 = 0;
    changed = 1'b0;
    for (int l = 0; l < lpe; l++) begin
      for (int cc = 0; cc < len; cc++) begin
        @(posedge clk);
        @(negedge clk);
        if (l == lpe / 2 && cc == len / 2) begin
          apply(nxt);
          changed = 1'b1;
        end
        pix_in = 10'(l * 37 + cc * 11 + 5);
        #1;
        ehs = (cc > c.bl);
        epv = ehs && (l < nl);
        k = cc - c.bl - 1;
        ecol = epv ? ((c.hs + (k / 2) * (2 << sh) + (k % 2)) % 1024) : 0;
        erow = epv ? ((c.vs + (l / 2) * (2 << sh) + (l % 2)) % 512) : 0;
        if (changed) begin
          check("R9 hsync after mid-frame rewrite", int'(hsync), int'(ehs));
          check("R9 col after mid-frame rewrite", int'(col_addr), ecol);
        end else begin
          check("R2 hsync", int'(hsync), int'(ehs));
          check("R6 col_addr", int'(col_addr), ecol);
        end
        check("R4 vsync", int'(vsync), int'(l == 0));
        check("R5 pix_valid", int'(pix_valid), int'(epv));
        check("R7 row_addr", int'(row_addr), erow);
        check("R8 pix_out", int'(pix_out), epv ? int'(pix_in) : 0);
        if (pix_valid) nvalid++;
        if (l == 0 && hsync) nhs0++;
      end
    end
    check("R3 hsync cycles per line", nhs0, np);
    if (first) check("R10 valid pixels in first frame", nvalid, np * ((nl < lpe) ? nl : lpe));
    else       check("R3 valid pixels per frame", nvalid, np * ((nl < lpe) ? nl : lpe));
  endtask

  initial begin
    list[0] = '{hs: 3,    vs: 2,   hz: 7,   vz: 5,  bl: 2,   lp: 8, sk: 0};
    list[1] = '{hs: 10,   vs: 1,   hz: 15,  vz: 7,  bl: 0,   lp: 6, sk: 1};
    list[2] = '{hs: 5,    vs: 0,   hz: 15,  vz: 15, bl: 4,   lp: 3, sk: 2};
    list[3] = '{hs: 1021, vs: 510, hz: 15,  vz: 7,  bl: 1,   lp: 0, sk: 3};
    list[4] = '{hs: 0,    vs: 0,   hz: 319, vz: 3,  bl: 136, lp: 4, sk: 1};
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        list[5 + s * 2 + b] = '{hs: 2 * s + 1, vs: 3 * b, hz: 15, vz: 7,
                                bl: 3 * b, lp: 10, sk: s};
      end
    end

    rst_n  = 1'b0;
    pix_in = 10'h155;
    apply(list[0]);
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    #1;
    check_idle("R1 after release");

    for (int i = 0; i < NCFG; i++) begin
      run_frame(list[i], list[(i + 1 < NCFG) ? i + 1 : i], i == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule